// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block sits on the device side of a synchronous DRAM command interface. It watches the chip-select, row-strobe, column-strobe and write-strobe inputs on every rising clock edge. It recognises WRITE commands and turns each one into a train of internal write strobes, and each strobe carries a bank, a column and the data word to store. The first word is taken on the very edge that registers the WRITE. Every later edge of the burst takes one more word at the next column.

A static configuration input selects bursts of 1, 2, 4 or 8 words, or a full page of 256 columns. A fixed-length burst steps through the columns in sequence and wraps inside its aligned block. A full-page burst wraps from column 255 to column 0 and runs until another command stops it. A new WRITE on any cycle cuts the running burst short and takes over at once. When address bit 10 is high with the WRITE, the block raises a one-cycle precharge request for the burst's bank after a burst that finishes on its own.

Top module: `sdr_wr_burst_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `wr_en` and `pre_req` are low.
- R2: A WRITE is `sel_n`=0, `row_strb_n`=1, `col_strb_n`=0 and `wr_strb_n`=0. On the cycle after the edge that samples it, `wr_en` is 1, `wr_bank` equals `bank_sel`, `wr_col` equals `addr[7:0]` and `wr_data` equals the `din` presented with the command. `addr[9:8]` have no effect on any output.
- R3: While `sel_n` is high the command is treated as a NOP, whatever the other strobes are: it starts no burst and a running burst continues.
- R4: `burst_cfg` latched with the WRITE sets the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives a full page.
- R5: Word k of a fixed burst of length L that starts at column s goes to column (s & ~(L-1)) | ((s+k) & (L-1)), and its data is the `din` sampled on the k-th edge after the WRITE edge.
- R6: Once a fixed burst has written its L words, and until the next WRITE, `wr_en` stays low and `din` has no effect.
- R7: A full-page burst writes consecutive columns. After column 255 it writes column 0, and it keeps going for as long as only NOPs follow.
- R8: A WRITE that arrives during a burst ends that burst at once. Its own data, column and bank, which may be either bank, appear on the next cycle, and the old burst writes no further words.
- R9: If `addr[10]` is high with a WRITE whose burst finishes by itself, `pre_req` is high for exactly one cycle, the cycle after the last `wr_en`, with `pre_bank` equal to the burst's bank. If `addr[10]` is low, `pre_req` stays low.
- R10: A burst that a new WRITE cuts short raises no `pre_req`, even if its own `addr[10]` was high.
- R11: A command with `sel_n` low that is neither WRITE nor NOP (`row_strb_n`, `col_strb_n` and `wr_strb_n` all high) ends a running burst: `wr_en` is low on the next cycle and no `pre_req` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling happens on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip select, active low |
| row_strb_n | input | 1 | Row strobe, active low |
| col_strb_n | input | 1 | Column strobe, active low |
| wr_strb_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Address: [7:0] start column, [10] auto-precharge enable |
| bank_sel | input | 1 | Bank select for the WRITE |
| din | input | 16 | Write data bus |
| burst_cfg | input | 3 | Static burst-length selection |
| wr_en | output | 1 | Internal write strobe |
| wr_bank | output | 1 | Bank of the current strobe |
| wr_col | output | 8 | Column of the current strobe |
| wr_data | output | 16 | Data of the current strobe |
| pre_req | output | 1 | One-cycle precharge request |
| pre_bank | output | 1 | Bank to precharge |

## Verification
Each word's strobe comes from one register stage, so a WRITE or NOP sampled on edge k shows its word on `wr_en`/`wr_col`/`wr_data` between edge k and edge k+1. The precharge request passes through one more stage and is due one cycle after the burst's last strobe. The bench drives every input on the falling edge and samples the outputs on the following falling edge, so each check falls in the cycle where its result is due. It then keeps checking for one or two more cycles to confirm that the strobes stop and that the precharge pulse lasts one cycle.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;

  localparam int COL_W = 8;
  localparam int CFG_W = 3;

  typedef logic [COL_W-1:0] col_t;
  typedef logic [CFG_W-1:0] cfg_t;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_OTHER = 2'd2
  } cmd_e;

  // Command decode from active-low strobes; deselected means idle.
  function automatic cmd_e decode_cmd(input logic sel_n, input logic row_n,
                                      input logic colm_n, input logic wrt_n);
    cmd_e c;
    if (sel_n)                              c = CMD_IDLE;
    else if (row_n && colm_n && wrt_n)      c = CMD_IDLE;
    else if (row_n && !colm_n && !wrt_n)    c = CMD_WRITE;
    else                                    c = CMD_OTHER;
    return c;
  endfunction

  // Wrap mask of a burst: length minus one, all ones for a full page.
  function automatic col_t burst_mask(input cfg_t cfg);
    col_t m;
    case (cfg)
      cfg_t'(0): m = col_t'(0);
      cfg_t'(1): m = col_t'(1);
      cfg_t'(2): m = col_t'(3);
      cfg_t'(3): m = col_t'(7);
      default:   m = '1;
    endcase
    return m;
  endfunction

  function automatic logic burst_is_page(input cfg_t cfg);
    return cfg > cfg_t'(3);
  endfunction

  // Column of word idx: upper bits fixed, low bits count modulo the length.
  function automatic col_t col_at(input col_t base, input col_t idx, input col_t mask);
    col_t sum;
    sum = base + idx;
    return (base & ~mask) | (sum & mask);
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_wr_pkg::*;
(
  input  logic sel_n,
  input  logic row_strb_n,
  input  logic col_strb_n,
  input  logic wr_strb_n,
  output logic cmd_write,
  output logic cmd_other
);

  cmd_e cmd;

  always_comb begin
    cmd       = decode_cmd(sel_n, row_strb_n, col_strb_n, wr_strb_n);
    cmd_write = (cmd == CMD_WRITE);
    cmd_other = (cmd == CMD_OTHER);
  end

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_wr_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_write,
  input  logic              cmd_other,
  input  col_t              start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              ap_in,
  input  cfg_t              len_cfg,
  output logic              beat,
  output col_t              beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              beat_fin_ap,
  output logic              burst_act,
  output logic              burst_full,
  output logic              burst_cut
);

  logic              act_q, full_q, ap_q;
  col_t              base_q, idx_q, mask_q;
  logic [BANK_W-1:0] bank_q;

  col_t new_mask;
  logic new_full, new_last, run_last, beat_cont, beat_last, beat_ap;

  always_comb begin
    new_mask    = burst_mask(len_cfg);
    new_full    = burst_is_page(len_cfg);
    new_last    = !new_full && (new_mask == '0);
    run_last    = !full_q && (idx_q == mask_q);
    beat_cont   = act_q && !cmd_write && !cmd_other;
    beat        = cmd_write || beat_cont;
    beat_col    = cmd_write ? start_col  : col_at(base_q, idx_q, mask_q);
    beat_bank   = cmd_write ? start_bank : bank_q;
    beat_ap     = cmd_write ? ap_in      : ap_q;
    beat_last   = cmd_write ? new_last   : (beat_cont && run_last);
    beat_fin_ap = beat && beat_last && beat_ap;
    burst_cut   = act_q && (cmd_write || cmd_other);
    burst_act   = act_q;
    burst_full  = full_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ap_q   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      bank_q <= '0;
    end else if (cmd_write) begin
      act_q  <= !new_last;
      full_q <= new_full;
      ap_q   <= ap_in;
      base_q <= start_col;
      idx_q  <= col_t'(1);
      mask_q <= new_mask;
      bank_q <= start_bank;
    end else if (beat_cont) begin
      idx_q <= idx_q + col_t'(1);
      if (run_last) act_q <= 1'b0;
    end else if (cmd_other) begin
      act_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdr_wr_stage.sv
module sdr_wr_stage
  import sdr_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  col_t              beat_col,
  input  logic [BANK_W-1:0] beat_bank,
  input  logic              beat_fin_ap,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output col_t              wr_col,
  output logic [BANK_W-1:0] wr_bank,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_ap,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank
);

  logic [BANK_W-1:0] done_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_col    <= '0;
      wr_bank   <= '0;
      wr_data   <= '0;
      done_ap   <= 1'b0;
      done_bank <= '0;
      pre_req   <= 1'b0;
      pre_bank  <= '0;
    end else begin
      wr_en   <= beat;
      done_ap <= beat_fin_ap;
      pre_req <= done_ap;
      if (beat) begin
        wr_col    <= beat_col;
        wr_bank   <= beat_bank;
        wr_data   <= din;
        done_bank <= beat_bank;
      end
      if (done_ap) pre_bank <= done_bank;
    end
  end

endmodule

// File: rtl/sdr_wr_burst_seq.sv
module sdr_wr_burst_seq
  import sdr_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              row_strb_n,
  input  logic              col_strb_n,
  input  logic              wr_strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_sel,
  input  logic [DATA_W-1:0] din,
  input  logic [CFG_W-1:0]  burst_cfg,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data,
  output logic              pre_req,
  output logic              pre_bank
);

  logic cmd_write, cmd_other;
  logic beat, beat_bank, beat_fin_ap;
  col_t beat_col;
  logic burst_act, burst_full, burst_cut, done_ap;
  logic unused_addr_bits;

  assign unused_addr_bits = ^addr[AP_BIT-1:COL_W] ^ burst_cut;

  sdr_cmd_decode u_dec (
    .sel_n      (sel_n),
    .row_strb_n (row_strb_n),
    .col_strb_n (col_strb_n),
    .wr_strb_n  (wr_strb_n),
    .cmd_write  (cmd_write),
    .cmd_other  (cmd_other)
  );

  sdr_burst_ctrl #(.BANK_W(1)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_write   (cmd_write),
    .cmd_other   (cmd_other),
    .start_col   (addr[COL_W-1:0]),
    .start_bank  (bank_sel),
    .ap_in       (addr[AP_BIT]),
    .len_cfg     (burst_cfg),
    .beat        (beat),
    .beat_col    (beat_col),
    .beat_bank   (beat_bank),
    .beat_fin_ap (beat_fin_ap),
    .burst_act   (burst_act),
    .burst_full  (burst_full),
    .burst_cut   (burst_cut)
  );

  sdr_wr_stage #(.DATA_W(DATA_W), .BANK_W(1)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (beat),
    .beat_col    (beat_col),
    .beat_bank   (beat_bank),
    .beat_fin_ap (beat_fin_ap),
    .din         (din),
    .wr_en       (wr_en),
    .wr_col      (wr_col),
    .wr_bank     (wr_bank),
    .wr_data     (wr_data),
    .done_ap     (done_ap),
    .pre_req     (pre_req),
    .pre_bank    (pre_bank)
  );

endmodule

// File: rtl/sdr_wr_burst_chk.sv
module sdr_wr_burst_chk
  import sdr_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_write,
  input logic              cmd_other,
  input logic              burst_act,
  input logic              burst_full,
  input logic              done_ap,
  input logic [ADDR_W-1:0] addr,
  input logic              bank_sel,
  input logic [DATA_W-1:0] din,
  input logic              wr_en,
  input logic              wr_bank,
  input col_t              wr_col,
  input logic [DATA_W-1:0] wr_data,
  input logic              pre_req,
  input logic              pre_bank
);

  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |=> (wr_en && wr_col == $past(addr[COL_W-1:0]) && wr_bank == $past(bank_sel) && wr_data == $past(din))); // R2

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_act && !cmd_write) |=> !wr_en); // R6

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_act && burst_full && !cmd_write && !cmd_other) |=> (wr_en && wr_col == $past(wr_col) + col_t'(1))); // R7

  AST_OTHER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_other |=> (!wr_en && !done_ap)); // R11

  AST_PRE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> ($past(wr_en) && pre_bank == $past(wr_bank))); // R9

  AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |=> !pre_req); // R9

endmodule

bind sdr_wr_burst_seq sdr_wr_burst_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_write  (cmd_write),
  .cmd_other  (cmd_other),
  .burst_act  (burst_act),
  .burst_full (burst_full),
  .done_ap    (done_ap),
  .addr       (addr),
  .bank_sel   (bank_sel),
  .din        (din),
  .wr_en      (wr_en),
  .wr_bank    (wr_bank),
  .wr_col     (wr_col),
  .wr_data    (wr_data),
  .pre_req    (pre_req),
  .pre_bank   (pre_bank)
);

// File: tb/sim_sdr_wr_burst_seq.sv
`timescale 1ns/1ps
module sim_sdr_wr_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b0, row_strb_n = 1'b1, col_strb_n = 1'b1, wr_strb_n = 1'b1;
  logic [10:0] addr = '0;
  logic        bank_sel = 1'b0;
  logic [15:0] din = '0;
  logic [2:0]  burst_cfg = '0;
  logic        wr_en, wr_bank, pre_req, pre_bank;
  logic [7:0]  wr_col;
  logic [15:0] wr_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdr_wr_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_strb_n(row_strb_n),
    .col_strb_n(col_strb_n), .wr_strb_n(wr_strb_n), .addr(addr),
    .bank_sel(bank_sel), .din(din), .burst_cfg(burst_cfg),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
    .pre_req(pre_req), .pre_bank(pre_bank)
  );

  typedef struct packed {
    logic [2:0]  cfg;
    logic [10:0] adr;
    logic        bnk;
    logic [3:0]  len;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{cfg: 3'd0, adr: 11'h405, bnk: 1'b0, len: 4'd1},
    '{cfg: 3'd1, adr: 11'h307, bnk: 1'b1, len: 4'd2},
    '{cfg: 3'd2, adr: 11'h60E, bnk: 1'b1, len: 4'd4},
    '{cfg: 3'd3, adr: 11'h0FB, bnk: 1'b0, len: 4'd8},
    '{cfg: 3'd3, adr: 11'h520, bnk: 1'b1, len: 4'd8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Command codes: 0 NOP, 1 WRITE, 2 deselected write pattern, 3 other selected command.
  task automatic step(input int cmd, input logic [10:0] a, input logic b, input logic [15:0] d);
    case (cmd)
      1:       {sel_n, row_strb_n, col_strb_n, wr_strb_n} = 4'b0100;
      2:       {sel_n, row_strb_n, col_strb_n, wr_strb_n} = 4'b1100;
      3:       {sel_n, row_strb_n, col_strb_n, wr_strb_n} = 4'b0011;
      default: {sel_n, row_strb_n, col_strb_n, wr_strb_n} = 4'b0111;
    endcase
    addr = a; bank_sel = b; din = d;
    @(negedge clk);
  endtask

  function automatic int exp_col(input int s, input int len, input int k);
    int off;
    off = s % len;
    return (s - off) + ((off + k) % len);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0 && pre_req == 1'b0, "R1 in reset", {wr_en, pre_req}, 0);
    rst_n = 1'b1;
    step(0, 11'h000, 1'b0, 16'h1111);
    chk(wr_en == 1'b0 && pre_req == 1'b0, "R1 after release", {wr_en, pre_req}, 0);

    // Vector table: fixed bursts
    foreach (VECS[i]) begin
      burst_cfg = VECS[i].cfg;
      for (int k = 0; k < int'(VECS[i].len); k++) begin
        logic [15:0] dv;
        int ec;
        dv = 16'hA000 + 16'(i * 16 + k);
        step(k == 0 ? 1 : 0, k == 0 ? VECS[i].adr : 11'h0FF, k == 0 ? VECS[i].bnk : ~VECS[i].bnk, dv);
        ec = exp_col(int'(VECS[i].adr[7:0]), int'(VECS[i].len), k);
        chk(wr_en == 1'b1, "R2 R4 strobe", wr_en, 1);
        chk(int'(wr_col) == ec, "R5 R2 column", wr_col, ec);
        chk(wr_data == dv, "R5 R2 data", wr_data, dv);
        chk(wr_bank == VECS[i].bnk, "R2 bank", wr_bank, VECS[i].bnk);
        chk(pre_req == 1'b0, "R9 no early precharge", pre_req, 0);
      end
      step(0, 11'h000, 1'b0, 16'hDEAD);
      chk(wr_en == 1'b0, "R6 burst ended", wr_en, 0);
      chk(pre_req == VECS[i].adr[10], "R9 precharge request", pre_req, VECS[i].adr[10]);
      if (VECS[i].adr[10])
        chk(pre_bank == VECS[i].bnk, "R9 precharge bank", pre_bank, VECS[i].bnk);
      step(0, 11'h000, 1'b0, 16'hBEEF);
      chk(wr_en == 1'b0 && pre_req == 1'b0, "R6 R9 quiet after burst", {wr_en, pre_req}, 0);
    end

    // Deselected write pattern starts nothing
    burst_cfg = 3'd3;
    step(2, 11'h412, 1'b1, 16'h5555);
    chk(wr_en == 1'b0, "R3 deselected write", wr_en, 0);
    step(0, 11'h000, 1'b0, 16'h0);
    chk(wr_en == 1'b0 && pre_req == 1'b0, "R3 still idle", {wr_en, pre_req}, 0);

    // Full page, config 7, start 0xFE, precharge enabled
    burst_cfg = 3'd7;
    for (int k = 0; k < 260; k++) begin
      logic [15:0] dv;
      int ec;
      dv = 16'h3000 + 16'(k);
      step(k == 0 ? 1 : 0, k == 0 ? 11'h4FE : 11'h000, 1'b1, dv);
      ec = (254 + k) % 256;
      chk(wr_en == 1'b1 && int'(wr_col) == ec && wr_data == dv, "R7 page column", {wr_en, wr_col}, {1'b1, 8'(ec)});
      chk(pre_req == 1'b0, "R7 no precharge while running", pre_req, 0);
    end
    step(3, 11'h000, 1'b0, 16'h0);
    chk(wr_en == 1'b0, "R11 other command stops", wr_en, 0);
    step(0, 11'h000, 1'b0, 16'h0);
    chk(wr_en == 1'b0 && pre_req == 1'b0, "R11 no precharge after stop", {wr_en, pre_req}, 0);
    step(0, 11'h000, 1'b0, 16'h0);
    chk(pre_req == 1'b0, "R11 no late precharge", pre_req, 0);

    // Config 5 is also full page; a deselected cycle keeps the burst going
    burst_cfg = 3'd5;
    for (int k = 0; k < 20; k++) begin
      step(k == 0 ? 1 : 0, k == 0 ? 11'h010 : 11'h000, 1'b0, 16'h4000 + 16'(k));
      chk(wr_en == 1'b1 && int'(wr_col) == 16 + k, "R4 config 5 full page", wr_col, 16 + k);
    end
    step(2, 11'h0AA, 1'b1, 16'h4444);
    chk(wr_en == 1'b1 && wr_col == 8'h24 && wr_data == 16'h4444 && wr_bank == 1'b0,
        "R3 deselect continues burst", wr_col, 8'h24);
    step(3, 11'h000, 1'b0, 16'h0);
    chk(wr_en == 1'b0, "R11 stop page burst", wr_en, 0);
    step(0, 11'h000, 1'b0, 16'h0);

    // Interrupt an 8-word burst with a write to the other bank
    burst_cfg = 3'd3;
    step(1, 11'h410, 1'b0, 16'h6000);
    step(0, 11'h000, 1'b0, 16'h6001);
    chk(wr_en == 1'b1 && wr_col == 8'h11, "R8 old burst second word", wr_col, 8'h11);
    step(1, 11'h033, 1'b1, 16'h7000);
    chk(wr_en == 1'b1 && wr_col == 8'h33 && wr_bank == 1'b1 && wr_data == 16'h7000,
        "R8 new write takes over", {wr_bank, wr_col}, {1'b1, 8'h33});
    for (int k = 1; k < 8; k++) begin
      int ec;
      step(0, 11'h000, 1'b0, 16'h7000 + 16'(k));
      ec = exp_col(8'h33, 8, k);
      chk(wr_en == 1'b1 && int'(wr_col) == ec && wr_bank == 1'b1, "R8 new burst column", wr_col, ec);
      chk(pre_req == 1'b0, "R10 no precharge for cut burst", pre_req, 0);
    end
    step(0, 11'h000, 1'b0, 16'h0);
    chk(wr_en == 1'b0 && pre_req == 1'b0, "R10 quiet after new burst", {wr_en, pre_req}, 0);
    step(0, 11'h000, 1'b0, 16'h0);
    chk(pre_req == 1'b0, "R10 no late precharge", pre_req, 0);

    // Cut on the edge that would carry the old burst's last word
    burst_cfg = 3'd1;
    step(1, 11'h440, 1'b0, 16'h8000);
    burst_cfg = 3'd0;
    step(1, 11'h050, 1'b1, 16'h8100);
    chk(wr_col == 8'h50 && wr_data == 16'h8100 && wr_bank == 1'b1, "R8 cut at last word", wr_col, 8'h50);
    step(0, 11'h000, 1'b0, 16'h0);
    chk(wr_en == 1'b0 && pre_req == 1'b0, "R10 cut last word no precharge", {wr_en, pre_req}, 0);
    step(0, 11'h000, 1'b0, 16'h0);
    chk(pre_req == 1'b0, "R10 cut last word still none", pre_req, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule